// File: doc/BRIEF.md
# Symbolic Seven-Segment State Display Driver

This block turns a small state number into a symbol on a seven-segment display. A producer presents a 4-bit code between 0 and 9 together with a valid strobe. The block looks up a fixed 8-bit pattern for that code, maps the pattern onto segments A to G, and holds the result in output registers that drive the display directly.

The display is rewritten only when a valid code differs from the code shown last. When that happens, a one-cycle `update_pulse` marks the change. After reset the record of the last shown code holds a value no legal code can equal, so the first legal code always reaches the display. Codes above 9 are discarded.

Top module: `symdisp_driver`

## Requirements
- R1: During and after synchronous reset, and until the first accepted code, `seg_out` is 7'h00 (all segments off, active high) and `update_pulse` is 0.
- R2: The 8-bit pattern for each code is: 0→8'h10, 1→8'h7E, 2→8'hC6, 3→8'hB0, 4→8'h80, 5→8'h08, 6→8'hCA, 7→8'h0C, 8→8'h02, 9→8'hE6.
- R3: `seg_out[k]` equals pattern bit k+1 for k = 0..6. `seg_out[0]` is segment A, and bits 1 to 4 are segments B to E. `seg_out[5]` is F and `seg_out[6]` is G. Pattern bit 0 drives no segment.
- R4: A valid code equal to the code last shown leaves `seg_out` unchanged and gives no `update_pulse`.
- R5: The first valid code from 0 to 9 after reset always updates `seg_out` and raises `update_pulse`.
- R6: A valid code from 10 to 15 changes neither `seg_out` nor the stored last-shown code. It raises no `update_pulse`.
- R7: An accepted change shows on `seg_out` from the first rising edge that samples it. `update_pulse` is high for exactly that one cycle. `seg_out` never changes while `update_pulse` is low.
- R8: While `code_valid` is low, `code_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Qualifies `code_in` for this cycle |
| code_in | input | 4 | State code, legal range 0 to 9 |
| seg_out | output | 7 | Segment drives, bit 0 = A through bit 6 = G, active high |
| update_pulse | output | 1 | High for one cycle after each display change |

## Verification
The assertions assume that `code_valid` and `code_in` are settled at every rising edge. They also assume that reset is held from time zero, so no check ever sees pre-reset values. The bench drives all inputs on the falling edge so that both assumptions hold. Its stimulus deliberately covers the whole 4-bit code space, including the illegal codes 10 to 15, and it switches the strobe on and off.

// File: rtl/symdisp_pkg.sv
package symdisp_pkg;

    localparam int STATE_W    = 4;
    localparam int NUM_STATES = 10;
    localparam int PAT_W      = 8;
    localparam int SEG_N      = 7;
    localparam int SEG_LSB    = 1;   // pattern bit that feeds segment A

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [PAT_W-1:0]   pattern_t;
    typedef logic [SEG_N-1:0]   seg_vec_t;

    // Value no legal code can match; marks "nothing shown yet"
    localparam state_t STATE_NONE = '1;

    function automatic logic state_legal(input state_t s);
        return s < state_t'(NUM_STATES);
    endfunction

    function automatic pattern_t state_pattern(input state_t s);
        pattern_t p;
        case (s)
            state_t'(0): p = 8'h10;
            state_t'(1): p = 8'h7E;
            state_t'(2): p = 8'hC6;
            state_t'(3): p = 8'hB0;
            state_t'(4): p = 8'h80;
            state_t'(5): p = 8'h08;
            state_t'(6): p = 8'hCA;
            state_t'(7): p = 8'h0C;
            state_t'(8): p = 8'h02;
            state_t'(9): p = 8'hE6;
            default:     p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/symdisp_lookup.sv
module symdisp_lookup
    import symdisp_pkg::*;
(
    input  state_t   state_i,
    output pattern_t pattern_o
);
    always_comb pattern_o = state_pattern(state_i);
endmodule

// File: rtl/symdisp_segmap.sv
module symdisp_segmap
    import symdisp_pkg::*;
(
    input  pattern_t pattern_i,
    output seg_vec_t seg_o
);
    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        assign seg_o[k] = pattern_i[k + SEG_LSB];
    end

    // R3: the line below segment A is reserved and must stay clear in every pattern
    always_comb begin
        assert_reserved_bit_clear_R3: assert (pattern_i[0] == 1'b0);
    end
endmodule

// File: rtl/symdisp_change.sv
module symdisp_change
    import symdisp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_i,
    input  state_t state_i,
    output logic   take_o
);
    state_t shown_q;

    always_comb take_o = valid_i && state_legal(state_i) && (state_i != shown_q);

    always_ff @(posedge clk) begin
        if (rst)         shown_q <= STATE_NONE;
        else if (take_o) shown_q <= state_i;
    end

    // R5/R6: the record holds either a legal code or the reset marker, never an ignored code
    assert_record_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (shown_q < state_t'(NUM_STATES)) || (shown_q == STATE_NONE));
endmodule

// File: rtl/symdisp_driver.sv
module symdisp_driver
    import symdisp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       code_valid,
    input  logic [3:0] code_in,
    output logic [6:0] seg_out,
    output logic       update_pulse
);
    pattern_t pat;
    seg_vec_t seg_next;
    logic     take;
    seg_vec_t seg_q;
    logic     pulse_q;

    symdisp_lookup u_lookup (
        .state_i   (state_t'(code_in)),
        .pattern_o (pat)
    );

    symdisp_segmap u_segmap (
        .pattern_i (pat),
        .seg_o     (seg_next)
    );

    symdisp_change u_change (
        .clk     (clk),
        .rst     (rst),
        .valid_i (code_valid),
        .state_i (state_t'(code_in)),
        .take_o  (take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= take;
            if (take) seg_q <= seg_next;
        end
    end

    assign seg_out      = seg_q;
    assign update_pulse = pulse_q;

    // R7: segments only move on a marked update
    assert_hold_without_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !update_pulse |-> $stable(seg_out));

    // R7: every marked update shows a different symbol
    assert_pulse_changes_seg_R7: assert property (@(posedge clk) disable iff (rst)
        update_pulse |-> !$stable(seg_out));

    // R6: illegal codes never cause an update
    assert_illegal_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_in > 4'd9) |=> !update_pulse);

    // R8: no strobe, no update
    assert_no_strobe_no_update_R8: assert property (@(posedge clk) disable iff (rst)
        !code_valid |=> !update_pulse);

    // R4: presenting the just-shown code again gives no update
    assert_repeat_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (update_pulse && code_valid && code_in == $past(code_in)) |=> !update_pulse);
endmodule

// File: tb/test_symdisp_driver.sv
module test_symdisp_driver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_valid = 1'b0;
    logic [3:0] code_in = 4'd0;
    logic [6:0] seg_out;
    logic       update_pulse;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [6:0] seg;
        logic       pulse;
        string      tag;
    } exp_t;
    exp_t q[$];

    // bench model
    logic [4:0] m_prev = 5'h10;  // no legal code matches
    logic [6:0] m_seg  = 7'h00;

    always #10 clk = ~clk;   // 50 MHz

    symdisp_driver i_symdisp_driver (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code_in(code_in),
        .seg_out(seg_out), .update_pulse(update_pulse)
    );

    function automatic logic [7:0] ref_pattern(input logic [3:0] c);
        case (c)
            4'd0: return 8'h10;  4'd1: return 8'h7E;
            4'd2: return 8'hC6;  4'd3: return 8'hB0;
            4'd4: return 8'h80;  4'd5: return 8'h08;
            4'd6: return 8'hCA;  4'd7: return 8'h0C;
            4'd8: return 8'h02;  4'd9: return 8'hE6;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    // driver: drive on falling edge, push expectation for the next rising edge
    task automatic send(input logic v, input logic [3:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        code_valid = v;
        code_in    = c;
        e.pulse = 1'b0;
        if (v && c <= 4'd9 && {1'b0, c} != m_prev) begin
            m_prev  = {1'b0, c};
            m_seg   = ref_pattern(c)[7:1];
            e.pulse = 1'b1;
        end
        e.seg = m_seg;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: sample 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(seg_out == e.seg && update_pulse == e.pulse, e.tag,
                  $sformatf("seg=%h pulse=%b expected seg=%h pulse=%b",
                            seg_out, update_pulse, e.seg, e.pulse));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        code_valid = 1'b1;  code_in = 4'd3;     // ignored under reset
        @(negedge clk);
        check(seg_out == 7'h00 && update_pulse == 1'b0, "R1",
              $sformatf("reset seg=%h pulse=%b expected seg=00 pulse=0", seg_out, update_pulse));
        code_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(seg_out == 7'h00 && update_pulse == 1'b0, "R1",
              $sformatf("idle seg=%h pulse=%b expected seg=00 pulse=0", seg_out, update_pulse));

        send(1, 4'd0, "R5 first code");
        send(1, 4'd0, "R4 repeat");
        send(0, 4'd5, "R8 no strobe");
        send(1, 4'd12, "R6 illegal");
        send(1, 4'd0, "R6 record kept");
        for (int s = 1; s <= 9; s++) send(1, 4'(s), "R2 R3 ascending");
        send(1, 4'd9, "R4 repeat top");
        send(1, 4'd15, "R6 illegal top");
        send(1, 4'd9, "R6 record kept top");
        for (int s = 8; s >= 0; s--) send(1, 4'(s), "R2 R3 descending");
        send(0, 4'd7, "R8 no strobe");
        send(1, 4'd7, "R7 single pulse");
        send(1, 4'd7, "R7 pulse drops");

        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send(lfsr[7], lfsr[3:0], "R7 mixed");
        end
        send(0, 4'd0, "R8 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule